// File: doc/BRIEF.md
# Reset Time-out Sequencer

This block keeps a processor core in reset after power comes up, or after it wakes from a low-power state, until its clocks can be trusted. It can chain up to three waits:

- a power-up wait, counted on strobes from a slow internal clock;
- an oscillator settle wait, counted on edges of the external oscillator;
- a fixed wait for the frequency multiplier to lock.

The configured oscillator mode, an active-low power-up-wait enable and the kind of event decide which of the waits run.

The waits begin when the power-on pulse ends. They count whether or not the external master-clear pin is held low. That pin only decides when the core is finally let go. A stage output shows which wait is in progress, so the order of the waits can be observed from outside.

Top module: `rts_seq`

## Requirements
- R1: While `rst` or `por_i` is high at a clock edge, `stage_o` becomes IDLE (0) and `core_rst_o` is 1 after that edge. At the first edge with `por_i` low, the sequence leaves IDLE.
- R2: The power-up wait (stage code 1) runs only after a power-on, and only when `pwrt_en_n_i` is 0. It lasts exactly 2048 `lf_tick_i` strobes. It always comes before any other wait.
- R3: Mode codes are 0=LP, 1=XT, 2=HS, 3=HS with multiplier, 4=EC, 5=RC, 6=internal. Codes 7 and above behave as internal. The oscillator wait (stage code 2) runs only for codes 0 to 3. It lasts exactly 1024 `osc_tick_i` strobes and follows the power-up wait.
- R4: In mode 3 only, a lock wait (stage code 3) of exactly 64 `lf_tick_i` strobes follows the oscillator wait.
- R5: After a power-on in modes 4 to 7 with `pwrt_en_n_i` at 1, the block reaches DONE (stage code 4) at the first edge after IDLE, and `core_rst_o` drops at that edge.
- R6: A `wake_i` strobe while in DONE never runs the power-up wait. In modes 0 to 3 it starts the oscillator wait, followed by the lock wait in mode 3. In other modes the block stays in DONE and `core_rst_o` stays 0.
- R7: `mclr_n_i` low at an edge makes `core_rst_o` 1 after that edge. It does not alter the stage or the counting. Once in DONE, `core_rst_o` falls at the first edge with `mclr_n_i` high.
- R8: `por_i` high during any stage returns the block to IDLE at that edge, and the whole sequence restarts. This holds even in the same cycle as a stage's final strobe.
- R9: A strobe from the clock that the current stage does not count has no effect on that stage's length.
- R10: `wake_i` has no effect outside DONE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; treated as a power-on |
| por_i | input | 1 | Power-on pulse, high while the supply is not yet valid |
| wake_i | input | 1 | One-cycle strobe: exit from a low-power state |
| mclr_n_i | input | 1 | External master clear, active low |
| lf_tick_i | input | 1 | One-cycle strobe per slow internal clock period |
| osc_tick_i | input | 1 | One-cycle strobe per external oscillator period |
| osc_mode_i | input | 3 | Oscillator mode code |
| pwrt_en_n_i | input | 1 | Power-up wait enable, active low |
| core_rst_o | output | 1 | Registered reset to the core, active high |
| stage_o | output | 3 | Current stage: 0 IDLE, 1 power-up, 2 oscillator, 3 lock, 4 DONE |

## Verification
A new power-on pulse can arrive in the same cycle as the strobe that would end a stage, and the restart must win.

The bench provokes this directly:

- it lets exactly 2047 slow strobes pass in the power-up wait;
- it then forces the 2048th strobe in the same cycle as `por_i`;
- it requires `stage_o` to read IDLE after that edge, not the oscillator wait.

A second collision is the release of master clear close to the end of the last wait. The cycle-level reference model judges it, because it updates `core_rst_o` at every edge from the stage and the master-clear level.

// File: rtl/rts_pkg.sv
package rts_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PWRT = 3'd1,
    ST_OST  = 3'd2,
    ST_PLL  = 3'd3,
    ST_DONE = 3'd4
  } rts_stage_e;

  localparam logic [2:0] MODE_LAST_XTAL = 3'd3;
  localparam logic [2:0] MODE_XTAL_PLL  = 3'd3;

  function automatic logic mode_is_xtal(input logic [2:0] mode);
    return mode <= MODE_LAST_XTAL;
  endfunction

endpackage

// File: rtl/rts_stage_plan.sv
module rts_stage_plan
  import rts_pkg::*;
(
  input  logic [2:0] osc_mode_i,
  input  logic       pwrt_en_n_i,
  output logic       use_pwrt_o,
  output logic       use_ost_o,
  output logic       use_pll_o
);

  always_comb begin
    use_pwrt_o = ~pwrt_en_n_i;
    use_ost_o  = mode_is_xtal(osc_mode_i);
    use_pll_o  = (osc_mode_i == MODE_XTAL_PLL);
  end

endmodule

// File: rtl/rts_tick_counter.sv
module rts_tick_counter #(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic          tick_i,
  input  logic [CW-1:0] last_val_i,
  output logic          expire_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) cnt_q <= '0;
    else if (tick_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = tick_i && (cnt_q == last_val_i);

endmodule

// File: rtl/rts_seq.sv
module rts_seq
  import rts_pkg::*;
#(
  parameter int PWRT_TICKS = 2048,
  parameter int OST_CYCLES = 1024,
  parameter int PLL_TICKS  = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       por_i,
  input  logic       wake_i,
  input  logic       mclr_n_i,
  input  logic       lf_tick_i,
  input  logic       osc_tick_i,
  input  logic [2:0] osc_mode_i,
  input  logic       pwrt_en_n_i,
  output logic       core_rst_o,
  output logic [2:0] stage_o
);

  localparam int MAX_A = (PWRT_TICKS > OST_CYCLES) ? PWRT_TICKS : OST_CYCLES;
  localparam int MAX_C = (MAX_A > PLL_TICKS) ? MAX_A : PLL_TICKS;
  localparam int CW    = (MAX_C > 2) ? $clog2(MAX_C) : 1;
  localparam logic [CW-1:0] PWRT_LAST = CW'(PWRT_TICKS - 1);
  localparam logic [CW-1:0] OST_LAST  = CW'(OST_CYCLES - 1);
  localparam logic [CW-1:0] PLL_LAST  = CW'(PLL_TICKS - 1);

  rts_stage_e stage_q, stage_d;
  logic       rst_q;
  logic       use_pwrt, use_ost, use_pll;
  logic       cnt_tick, cnt_clr, cnt_expire;
  logic [CW-1:0] cnt_last;

  rts_stage_plan u_plan (
    .osc_mode_i (osc_mode_i),
    .pwrt_en_n_i(pwrt_en_n_i),
    .use_pwrt_o (use_pwrt),
    .use_ost_o  (use_ost),
    .use_pll_o  (use_pll)
  );

  // Tick source and terminal value for the stage in progress
  always_comb begin
    cnt_tick = 1'b0;
    cnt_last = PWRT_LAST;
    unique case (stage_q)
      ST_PWRT: begin cnt_tick = lf_tick_i;  cnt_last = PWRT_LAST; end
      ST_OST:  begin cnt_tick = osc_tick_i; cnt_last = OST_LAST;  end
      ST_PLL:  begin cnt_tick = lf_tick_i;  cnt_last = PLL_LAST;  end
      default: begin cnt_tick = 1'b0;       cnt_last = PWRT_LAST; end
    endcase
  end

  rts_tick_counter #(.CW(CW)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .clr_i     (cnt_clr),
    .tick_i    (cnt_tick),
    .last_val_i(cnt_last),
    .expire_o  (cnt_expire)
  );

  always_comb begin
    stage_d = stage_q;
    unique case (stage_q)
      ST_IDLE: stage_d = use_pwrt ? ST_PWRT : (use_ost ? ST_OST : ST_DONE);
      ST_PWRT: if (cnt_expire) stage_d = use_ost ? ST_OST : ST_DONE;
      ST_OST:  if (cnt_expire) stage_d = use_pll ? ST_PLL : ST_DONE;
      ST_PLL:  if (cnt_expire) stage_d = ST_DONE;
      ST_DONE: if (wake_i) stage_d = use_ost ? ST_OST : ST_DONE;
      default: stage_d = ST_IDLE;
    endcase
    if (por_i) stage_d = ST_IDLE;
  end

  assign cnt_clr = por_i || (stage_d != stage_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= ST_IDLE;
      rst_q   <= 1'b1;
    end else begin
      stage_q <= stage_d;
      rst_q   <= (stage_d != ST_DONE) || !mclr_n_i;
    end
  end

  assign core_rst_o = rst_q;
  assign stage_o    = stage_q;

endmodule

// File: rtl/rts_seq_chk.sv
module rts_seq_chk
  import rts_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       por_i,
  input logic       wake_i,
  input logic       mclr_n_i,
  input logic [2:0] osc_mode_i,
  input logic       core_rst_o,
  input logic [2:0] stage_o
);

  AST_POR_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    por_i |=> (stage_o == ST_IDLE) && core_rst_o); // R8

  AST_MCLR_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !mclr_n_i |=> core_rst_o); // R7

  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (stage_o == ST_DONE && $past(mclr_n_i)) |-> !core_rst_o); // R7

  AST_RST_OUTSIDE_DONE: assert property (@(posedge clk) disable iff (rst)
    (stage_o != ST_DONE) |-> core_rst_o); // R1

  AST_OST_XTAL_ONLY: assert property (@(posedge clk) disable iff (rst)
    (stage_o == ST_OST) |-> (osc_mode_i <= 3'd3)); // R3

  AST_PLL_MODE_ONLY: assert property (@(posedge clk) disable iff (rst)
    (stage_o == ST_PLL) |-> (osc_mode_i == 3'd3)); // R4

  AST_WAKE_NO_PWRT: assert property (@(posedge clk) disable iff (rst)
    (stage_o == ST_DONE && wake_i && !por_i) |=> (stage_o != ST_PWRT)); // R6

  AST_PWRT_FIRST: assert property (@(posedge clk) disable iff (rst)
    (stage_o == ST_OST || stage_o == ST_PLL) |=> (stage_o != ST_PWRT)); // R2

endmodule

bind rts_seq rts_seq_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .por_i     (por_i),
  .wake_i    (wake_i),
  .mclr_n_i  (mclr_n_i),
  .osc_mode_i(osc_mode_i),
  .core_rst_o(core_rst_o),
  .stage_o   (stage_o)
);

// File: tb/rts_seq_tb.sv
`timescale 1ns/1ps
module rts_seq_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       por_i = 1'b1, wake_i = 1'b0, mclr_n_i = 1'b1;
  logic       lf_tick_i = 1'b0, osc_tick_i = 1'b0;
  logic [2:0] osc_mode_i = 3'd2;
  logic       pwrt_en_n_i = 1'b0;
  logic       core_rst_o;
  logic [2:0] stage_o;

  always #5 clk = ~clk;

  rts_seq u_dut (
    .clk(clk), .rst(rst), .por_i(por_i), .wake_i(wake_i), .mclr_n_i(mclr_n_i),
    .lf_tick_i(lf_tick_i), .osc_tick_i(osc_tick_i), .osc_mode_i(osc_mode_i),
    .pwrt_en_n_i(pwrt_en_n_i), .core_rst_o(core_rst_o), .stage_o(stage_o)
  );

  int total = 0, bad = 0;
  int n_pwrt, n_ost, n_pll, seq_code, last_st;
  bit force_lf = 0;

  // Behavioural reference: stage number, ticks seen in stage, reset level
  int m_st = 0, m_cnt = 0;
  bit m_rst = 1;

  function automatic bit xtal(input logic [2:0] m); return m <= 3; endfunction

  always @(posedge clk) begin
    int nx;
    bit ticked;
    if (rst) begin
      m_st = 0; m_cnt = 0; m_rst = 1;
    end else begin
      nx = m_st;
      ticked = (m_st == 1 && lf_tick_i) || (m_st == 2 && osc_tick_i) || (m_st == 3 && lf_tick_i);
      if (m_st == 0)      nx = !pwrt_en_n_i ? 1 : (xtal(osc_mode_i) ? 2 : 4);
      else if (m_st == 4) begin if (wake_i) nx = xtal(osc_mode_i) ? 2 : 4; end
      else if (ticked) begin
        if (m_st == 1 && m_cnt + 1 == 2048) nx = xtal(osc_mode_i) ? 2 : 4;
        if (m_st == 2 && m_cnt + 1 == 1024) nx = (osc_mode_i == 3) ? 3 : 4;
        if (m_st == 3 && m_cnt + 1 == 64)   nx = 4;
      end
      if (por_i) nx = 0;
      if (nx != m_st) m_cnt = 0; else if (ticked) m_cnt++;
      m_st = nx;
      m_rst = (m_st != 4) || !mclr_n_i;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic string tag_of(input int st);
    case (st)
      0: return "R1"; 1: return "R2"; 2: return "R3"; 3: return "R4";
      default: return "R7";
    endcase
  endfunction

  task automatic step();
    lf_tick_i  = force_lf ? 1'b1 : 1'($urandom_range(0, 1));
    osc_tick_i = 1'($urandom_range(0, 1));
    if (stage_o == 3'd1 && lf_tick_i)  n_pwrt++;
    if (stage_o == 3'd2 && osc_tick_i) n_ost++;
    if (stage_o == 3'd3 && lf_tick_i)  n_pll++;
    @(posedge clk);
    @(negedge clk);
    force_lf = 0;
    check(int'(stage_o) == m_st, tag_of(m_st), stage_o, m_st);
    check(core_rst_o == m_rst, "R7", core_rst_o, m_rst);
    if (int'(stage_o) != last_st) begin
      seq_code = seq_code * 10 + int'(stage_o);
      last_st  = int'(stage_o);
    end
  endtask

  task automatic clear_tally();
    n_pwrt = 0; n_ost = 0; n_pll = 0; seq_code = 0; last_st = int'(stage_o);
  endtask

  task automatic run_done();
    for (int i = 0; i < 20000 && stage_o != 3'd4; i++) step();
  endtask

  task automatic por_pulse();
    por_i = 1; step(); por_i = 0; clear_tally();
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 190000) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=%0d", wd, 190000);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    @(negedge clk);
    clear_tally();
    repeat (3) step();
    rst = 0;
    repeat (2) step();
    check(stage_o == 3'd0 && core_rst_o, "R1", stage_o, 0);

    // HS with power-up wait
    por_i = 0; clear_tally();
    run_done();
    check(seq_code == 124, "R2", seq_code, 124);
    check(n_pwrt == 2048, "R2", n_pwrt, 2048);
    check(n_ost == 1024, "R3", n_ost, 1024);
    check(n_ost == 1024 && n_pwrt == 2048, "R9", n_pwrt + n_ost, 3072);
    check(core_rst_o == 0, "R7", core_rst_o, 0);

    // HS with multiplier
    osc_mode_i = 3'd3;
    por_i = 1; step();
    check(stage_o == 3'd0 && core_rst_o, "R8", stage_o, 0);
    por_i = 0; clear_tally();
    run_done();
    check(seq_code == 1234, "R4", seq_code, 1234);
    check(n_pll == 64, "R4", n_pll, 64);

    // RC, no power-up wait: immediate release
    osc_mode_i = 3'd5; pwrt_en_n_i = 1;
    por_pulse(); step();
    check(stage_o == 3'd4 && !core_rst_o, "R5", core_rst_o, 0);
    osc_mode_i = 3'd7;
    por_pulse(); step();
    check(stage_o == 3'd4 && !core_rst_o, "R5", stage_o, 4);

    // Wake: LP runs oscillator wait only, EC stays released
    osc_mode_i = 3'd0; pwrt_en_n_i = 0;
    clear_tally(); wake_i = 1; step(); wake_i = 0;
    check(stage_o == 3'd2, "R6", stage_o, 2);
    run_done();
    check(seq_code == 24 && n_pwrt == 0, "R6", seq_code, 24);
    osc_mode_i = 3'd4;
    wake_i = 1; step(); wake_i = 0;
    check(stage_o == 3'd4 && !core_rst_o, "R6", core_rst_o, 0);

    // Master clear low throughout the waits
    osc_mode_i = 3'd2; mclr_n_i = 0;
    por_pulse(); run_done();
    check(stage_o == 3'd4 && core_rst_o, "R7", core_rst_o, 1);
    mclr_n_i = 1; step();
    check(!core_rst_o, "R7", core_rst_o, 0);
    mclr_n_i = 0; step();
    check(core_rst_o && stage_o == 3'd4, "R7", core_rst_o, 1);
    mclr_n_i = 1; step();

    // Restart mid power-up wait; wake ignored there
    por_pulse();
    repeat (100) step();
    check(stage_o == 3'd1, "R2", stage_o, 1);
    wake_i = 1; step(); wake_i = 0;
    check(stage_o == 3'd1, "R10", stage_o, 1);
    por_i = 1; step();
    check(stage_o == 3'd0, "R8", stage_o, 0);
    por_i = 0; clear_tally();
    run_done();
    check(n_pwrt == 2048, "R8", n_pwrt, 2048);

    // Power-on in the same cycle as the final power-up strobe
    por_pulse();
    for (int i = 0; i < 20000 && n_pwrt < 2047; i++) step();
    force_lf = 1; por_i = 1; step(); por_i = 0;
    check(stage_o == 3'd0, "R8", stage_o, 0);
    clear_tally(); run_done();
    check(seq_code == 124, "R8", seq_code, 124);

    // Internal oscillator with power-up wait only
    osc_mode_i = 3'd6;
    por_pulse(); run_done();
    check(seq_code == 14 && n_pwrt == 2048, "R3", seq_code, 14);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule